// File: doc/BRIEF.md
# Oscillator Alarm and Shutdown Controller

This block watches a bank of free-running ring oscillators used as entropy sources. Every oscillator has its own alarm-event input, an enable, a detune setting and an alarm mask bit. A per-oscillator counter tallies unmasked alarm events against a shared programmable threshold. The alarm that arrives while the tally already equals the threshold is an error event, and it clears the tally. The first error event only puts the oscillator on warning. The second takes it out of service: its enable drops, its bit is recorded in the stop register, and a one-cycle shutdown pulse goes out toward the status logic.

The host uses a simple synchronous register port. A typical recovery reads the stop register, writes that pattern into the detune register, clears the mask and stop records by writing zero, and writes the enable register with ones to re-arm. The random bits of each oscillator pass through gated by its enable. Combining them is done elsewhere.

Each oscillator has a four-state machine:
- `CH_OFF` moves to `CH_ARMED` on an enable write with its bit at 1 (arm).
- `CH_ARMED` moves to `CH_WARNED` on the first error event (warn). It moves to `CH_OFF` on an enable write with its bit at 0 (disarm).
- `CH_WARNED` moves to `CH_HALTED` on a second error event (halt). It moves to `CH_OFF` on an enable write with its bit at 0 (disarm). A halt outranks a disarm in the same cycle.
- `CH_HALTED` moves to `CH_ARMED` on an enable write with its bit at 1 (re-arm).

Top module: `osc_alarm_ctrl`

## Requirements
- R1: After reset every oscillator is in `CH_OFF`, `osc_en` is 0, the mask, stop and detune registers are 0, the threshold register reads 0xFF, and `shutdown_evt` is 0.
- R2: The register map is: threshold at 0x1C (bits 7:0, upper bits read 0), enable at 0x20, detune at 0x24, mask at 0x28 and stop at 0x2C, with bit i belonging to oscillator i. `reg_rdata` returns the addressed register in the same cycle. Other addresses read 0, and writes to them change nothing.
- R3: A write to the enable register arms every oscillator whose bit is 1 and that is off or halted. It disarms every oscillator whose bit is 0. Reading the enable register and the `osc_en` port both show the oscillators that are in `CH_ARMED` or `CH_WARNED`, from the cycle after the write.
- R4: Each alarm on an enabled, unmasked oscillator adds one to its tally. The alarm that arrives when the tally equals the threshold is an error event and resets the tally to 0. So with threshold T, an error event needs T+1 alarms.
- R5: The first error event never shuts an oscillator down. The second one clears its enable and sets its stop bit at the same clock edge.
- R6: `shutdown_evt` is high for exactly the one cycle that follows the edge at which one or more oscillators shut down.
- R7: Alarms on an oscillator whose mask bit is 1 are ignored. They never advance its tally and never cause a shutdown.
- R8: Alarms on an oscillator that is off or halted are ignored and leave no warning behind for the next time it is armed.
- R9: Re-arming starts the oscillator with a tally of 0 and no warning. Re-arming does not clear its stop bit. Writing 0 to the stop or mask register clears those records.
- R10: A shutdown sets its stop bit even when the host writes the stop register in the same cycle.
- R11: `osc_live` equals `osc_bits` ANDed with `osc_en`, and `osc_detune` mirrors the detune register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| alarm_in | input | 32 | Per-oscillator alarm event pulses |
| osc_bits | input | 32 | Per-oscillator random bit |
| osc_en | output | 32 | Per-oscillator run enable |
| osc_detune | output | 32 | Per-oscillator detune setting |
| osc_live | output | 32 | Random bits gated by enable |
| shutdown_evt | output | 1 | One-cycle shutdown overflow event |

## Verification
The shutdown path is driven with single-oscillator alarm bursts of chosen length:
- At a threshold of 1, three alarms must leave the oscillator running and the fourth must stop it. This separates an off-by-one in the threshold compare from a machine that halts on its first error event.
- The same bursts are sent to a masked oscillator and to disabled ones, so that ignored alarms can be told apart from counted ones through the enable and stop records.
- Re-arming after a halt, followed by a single error event, shows whether the warning state survives a restart.
- An alarm that lands in the same cycle as a host write of zero to the stop register exposes the priority between the two.

// File: rtl/osc_sup_pkg.sv
package osc_sup_pkg;

    localparam logic [7:0] ADDR_THR    = 8'h1C;
    localparam logic [7:0] ADDR_EN     = 8'h20;
    localparam logic [7:0] ADDR_DETUNE = 8'h24;
    localparam logic [7:0] ADDR_MASK   = 8'h28;
    localparam logic [7:0] ADDR_STOP   = 8'h2C;

    typedef enum logic [1:0] {
        CH_OFF     = 2'd0,
        CH_ARMED   = 2'd1,
        CH_WARNED  = 2'd2,
        CH_HALTED  = 2'd3
    } ch_state_t;

endpackage

// File: rtl/osc_reg_file.sv
module osc_reg_file
    import osc_sup_pkg::*;
#(
    parameter int N      = 32,
    parameter int THR_W  = 8,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [N-1:0]      stop_set,
    input  logic [N-1:0]      en_state,
    output logic [DATA_W-1:0] rdata,
    output logic [THR_W-1:0]  thr_q,
    output logic [N-1:0]      detune_q,
    output logic [N-1:0]      mask_q,
    output logic [N-1:0]      stop_q,
    output logic              en_wr,
    output logic [N-1:0]      en_wdata
);

    localparam logic [THR_W-1:0] THR_RESET = '1;

    logic wr_thr, wr_det, wr_mask, wr_stop;

    always_comb begin
        wr_thr   = we && (addr == ADDR_W'(ADDR_THR));
        wr_det   = we && (addr == ADDR_W'(ADDR_DETUNE));
        wr_mask  = we && (addr == ADDR_W'(ADDR_MASK));
        wr_stop  = we && (addr == ADDR_W'(ADDR_STOP));
        en_wr    = we && (addr == ADDR_W'(ADDR_EN));
        en_wdata = wdata[N-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_q    <= THR_RESET;
            detune_q <= '0;
            mask_q   <= '0;
            stop_q   <= '0;
        end else begin
            if (wr_thr)  thr_q    <= wdata[THR_W-1:0];
            if (wr_det)  detune_q <= wdata[N-1:0];
            if (wr_mask) mask_q   <= wdata[N-1:0];
            // a shutdown record is never lost to a host write in the same cycle
            stop_q <= (wr_stop ? wdata[N-1:0] : stop_q) | stop_set;
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            ADDR_W'(ADDR_THR):    rdata[THR_W-1:0] = thr_q;
            ADDR_W'(ADDR_EN):     rdata[N-1:0]     = en_state;
            ADDR_W'(ADDR_DETUNE): rdata[N-1:0]     = detune_q;
            ADDR_W'(ADDR_MASK):   rdata[N-1:0]     = mask_q;
            ADDR_W'(ADDR_STOP):   rdata[N-1:0]     = stop_q;
            default:              rdata            = '0;
        endcase
    end

    // R10: any requested stop bit is present after the edge
    assert_stop_set_sticks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_set != '0) |=> ((stop_q & $past(stop_set)) == $past(stop_set)));

endmodule

// File: rtl/osc_chan.sv
module osc_chan
    import osc_sup_pkg::*;
#(
    parameter int THR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_wr_i,
    input  logic             en_bit_i,
    input  logic             mask_i,
    input  logic             alarm_i,
    input  logic [THR_W-1:0] thr_i,
    output logic             en_o,
    output logic             halt_o
);

    ch_state_t        state_q, state_d;
    logic [THR_W-1:0] cnt_q, cnt_d;
    logic             live, counted, err, arm, disarm;

    always_comb begin
        live    = (state_q == CH_ARMED) || (state_q == CH_WARNED);
        counted = live && alarm_i && !mask_i;
        err     = counted && (cnt_q == thr_i);
        arm     = en_wr_i && en_bit_i;
        disarm  = en_wr_i && !en_bit_i;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_OFF:     if (arm) state_d = CH_ARMED;
            CH_ARMED: begin
                if (disarm)   state_d = CH_OFF;
                else if (err) state_d = CH_WARNED;
            end
            CH_WARNED: begin
                if (err)         state_d = CH_HALTED;
                else if (disarm) state_d = CH_OFF;
            end
            CH_HALTED:  if (arm) state_d = CH_ARMED;
            default:    state_d = CH_OFF;
        endcase
    end

    always_comb begin
        cnt_d = cnt_q;
        if (!live && arm)  cnt_d = '0;
        else if (err)      cnt_d = '0;
        else if (counted)  cnt_d = cnt_q + 1'b1;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CH_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        en_o   = 1'b0;
        halt_o = 1'b0;
        unique case (state_q)
            CH_OFF:    en_o = 1'b0;
            CH_ARMED:  en_o = 1'b1;
            CH_WARNED: begin
                en_o   = 1'b1;
                halt_o = err;
            end
            CH_HALTED: en_o = 1'b0;
            default:   en_o = 1'b0;
        endcase
    end

    assert_first_error_keeps_running_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_ARMED) |=> (state_q != CH_HALTED));

    assert_masked_alarm_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_i && !en_wr_i) |=> ($stable(cnt_q) && $stable(state_q)));

    assert_off_alarm_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_o && !en_wr_i) |=> ($stable(cnt_q) && $stable(state_q)));

    assert_rearm_clears_tally_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (en_wr_i && en_bit_i && !en_o) |=> ((cnt_q == '0) && (state_q == CH_ARMED)));

endmodule

// File: rtl/osc_alarm_ctrl.sv
module osc_alarm_ctrl
    import osc_sup_pkg::*;
#(
    parameter int N      = 32,
    parameter int THR_W  = 8,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [N-1:0]      alarm_in,
    input  logic [N-1:0]      osc_bits,
    output logic [N-1:0]      osc_en,
    output logic [N-1:0]      osc_detune,
    output logic [N-1:0]      osc_live,
    output logic              shutdown_evt
);

    logic [THR_W-1:0] thr_q;
    logic [N-1:0]     detune_q, mask_q, stop_q, en_wdata, halt;
    logic             en_wr, shut_q;

    osc_reg_file #(
        .N(N), .THR_W(THR_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (reg_we),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .stop_set (halt),
        .en_state (osc_en),
        .rdata    (reg_rdata),
        .thr_q    (thr_q),
        .detune_q (detune_q),
        .mask_q   (mask_q),
        .stop_q   (stop_q),
        .en_wr    (en_wr),
        .en_wdata (en_wdata)
    );

    for (genvar i = 0; i < N; i++) begin : g_chan
        osc_chan #(.THR_W(THR_W)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .en_wr_i  (en_wr),
            .en_bit_i (en_wdata[i]),
            .mask_i   (mask_q[i]),
            .alarm_i  (alarm_in[i]),
            .thr_i    (thr_q),
            .en_o     (osc_en[i]),
            .halt_o   (halt[i])
        );

        assert_halt_drops_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
            halt[i] |=> (!osc_en[i] && stop_q[i]));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) shut_q <= 1'b0;
        else        shut_q <= |halt;
    end

    always_comb begin
        shutdown_evt = shut_q;
        osc_live     = osc_bits & osc_en;
        osc_detune   = detune_q;
    end

    assert_event_has_record_R6: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_evt |-> (stop_q != '0));

endmodule

// File: tb/sim_osc_alarm_ctrl.sv
`timescale 1ns/1ps
module sim_osc_alarm_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] alarm_in = '0;
    logic [31:0] osc_bits = '0;
    logic [31:0] osc_en, osc_detune, osc_live;
    logic        shutdown_evt;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    osc_alarm_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .alarm_in(alarm_in),
        .osc_bits(osc_bits), .osc_en(osc_en), .osc_detune(osc_detune),
        .osc_live(osc_live), .shutdown_evt(shutdown_evt)
    );

    // {addr, write data, expected read-back}
    localparam logic [71:0] VEC [10] = '{
        {8'h1C, 32'h0000_1234, 32'h0000_0034},
        {8'h24, 32'hA5A5_F00F, 32'hA5A5_F00F},
        {8'h28, 32'hFFFF_0000, 32'hFFFF_0000},
        {8'h28, 32'h0000_0000, 32'h0000_0000},
        {8'h2C, 32'h0000_FF00, 32'h0000_FF00},
        {8'h2C, 32'h0000_0000, 32'h0000_0000},
        {8'h20, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
        {8'h20, 32'h0000_0000, 32'h0000_0000},
        {8'h30, 32'h0000_DEAD, 32'h0000_0000},
        {8'h00, 32'h1234_5678, 32'h0000_0000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        step();
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic fire(input logic [31:0] v);
        alarm_in = v;
        step();
        alarm_in = '0;
    endtask

    initial begin
        #1_000_000;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) step();
        rst_n = 1'b1;
        #1;
        // R1 reset state
        rd(8'h1C, d); chk("R1 threshold", d, 32'hFF);
        chk("R1 enable", osc_en, 32'h0);
        chk("R1 shutdown", {31'h0, shutdown_evt}, 32'h0);
        rd(8'h2C, d); chk("R1 stop", d, 32'h0);
        rd(8'h24, d); chk("R1 detune", d, 32'h0);

        // R2 / R3 register table
        for (int k = 0; k < 10; k++) begin
            wr(VEC[k][71:64], VEC[k][63:32]);
            rd(VEC[k][71:64], d);
            chk("R2 register readback", d, VEC[k][31:0]);
        end
        rd(8'h28, d); chk("R2 unmapped write left mask", d, 32'h0);

        // R11 gating and detune output
        osc_bits = 32'hFFFF_FFFF;
        wr(8'h20, 32'h0000_00F0);
        chk("R3 enable port", osc_en, 32'h0000_00F0);
        chk("R11 live gating", osc_live, 32'h0000_00F0);
        wr(8'h24, 32'h0000_0F0F);
        chk("R11 detune out", osc_detune, 32'h0000_0F0F);
        wr(8'h20, 32'h0);
        chk("R3 disarm", osc_en, 32'h0);

        // R4 / R5 / R6 threshold 1: fourth alarm is the second error event
        wr(8'h1C, 32'h1);
        wr(8'h20, 32'h8);
        for (int k = 0; k < 3; k++) fire(32'h8);
        chk("R4 three alarms keep running", osc_en, 32'h8);
        chk("R5 no event after first error", {31'h0, shutdown_evt}, 32'h0);
        fire(32'h8);
        chk("R5 halted enable", osc_en, 32'h0);
        chk("R6 pulse high", {31'h0, shutdown_evt}, 32'h1);
        rd(8'h2C, d); chk("R5 stop bit", d, 32'h8);
        step();
        chk("R6 pulse one cycle", {31'h0, shutdown_evt}, 32'h0);

        // R9 re-arm
        wr(8'h20, 32'h8);
        chk("R9 rearmed", osc_en, 32'h8);
        rd(8'h2C, d); chk("R9 stop kept", d, 32'h8);
        wr(8'h1C, 32'h0);
        fire(32'h8);
        chk("R9 warning cleared on rearm", osc_en, 32'h8);
        wr(8'h2C, 32'h0);
        rd(8'h2C, d); chk("R9 stop cleared", d, 32'h0);
        wr(8'h20, 32'h0);

        // R7 mask
        wr(8'h28, 32'h20);
        wr(8'h20, 32'h20);
        for (int k = 0; k < 5; k++) fire(32'h20);
        chk("R7 masked keeps running", osc_en, 32'h20);
        rd(8'h2C, d); chk("R7 masked no stop", d, 32'h0);
        wr(8'h28, 32'h0);
        rd(8'h28, d); chk("R9 mask cleared", d, 32'h0);
        fire(32'h20);
        fire(32'h20);
        chk("R7 unmasked halts", osc_en, 32'h0);
        rd(8'h2C, d); chk("R7 unmasked stop", d, 32'h20);
        wr(8'h2C, 32'h0);

        // R8 alarms while off
        wr(8'h20, 32'h0);
        for (int k = 0; k < 3; k++) begin
            fire(32'hFFFF_FFFF);
            chk("R8 no event while off", {31'h0, shutdown_evt}, 32'h0);
        end
        rd(8'h2C, d); chk("R8 no stop while off", d, 32'h0);
        wr(8'h20, 32'h80);
        fire(32'h80);
        chk("R8 no leftover warning", osc_en, 32'h80);
        wr(8'h20, 32'h0);

        // R10 shutdown beats host stop write
        wr(8'h20, 32'h200);
        fire(32'h200);
        alarm_in = 32'h200;
        wr(8'h2C, 32'h0);
        alarm_in = '0;
        rd(8'h2C, d); chk("R10 stop set wins", d, 32'h200);
        chk("R10 halted", osc_en, 32'h0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule